// File: doc/BRIEF.md
# GPIO Port Register Controller

This block is the register front end of a 32-pin general-purpose I/O port. A 32-bit register bus (address, write strobe, write data, read strobe, read data) gives software access to an output word, a direction word, one configuration word per pin and a read-only view of the pin levels. The output word goes straight to the pads as `out_level`, and the direction word goes to the pads as `dir_mask`. Pad resolution is not part of this block. The pad levels arrive already resolved on `pin_level`, and the block registers them before software can read them.

The output word and the direction word can each be written in three ways: a full assignment, a set alias that ORs the written bits in, or a clear alias that removes the written bits. The direction of a pin can be seen and written in two places: the port-wide direction word and bit 0 of that pin's configuration word. Both views are backed by a single stored bit, so they can never disagree.

Reads are registered. The data for a read presented in one cycle appears on `bus_rdata` in the next cycle, and it reflects the state from before any write in that same cycle. An access to an offset that has no register returns zero, has no effect, and raises `bus_err` for one cycle.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A write to OUT (0x504) replaces the output word. A write to OUTSET (0x508) ORs the data into it. A write to OUTCLR (0x50C) clears every bit that is 1 in the data. `out_level` shows the new word from the cycle after the write edge.
- R2: DIR (0x514), DIRSET (0x518) and DIRCLR (0x51C) act on the direction word in the same three ways. `dir_mask` shows the new word from the cycle after the write edge.
- R3: A read of OUT, OUTSET or OUTCLR returns the output word. A read of DIR, DIRSET or DIRCLR returns the direction word.
- R4: After any write through the direction aliases, bit 0 of each pin's configuration word reads back equal to that pin's bit in the direction word (1 = output).
- R5: A write to pin n's configuration word stores bits 31:1 as written. It also copies written bit 0 into bit n of the direction word and leaves the other direction bits and the other configuration words unchanged.
- R6: The configuration word of pin n sits at offset 0x700 + 4*n, for n = 0..31.
- R7: Reset is synchronous and active high. It clears the output and direction words to 0 and sets every configuration word to 0x00000002.
- R8: A read of IN (0x510) returns `pin_level` as it was sampled one clock earlier. A write to IN has no effect on any register.
- R9: A read of an unmapped offset, including any offset whose two low bits are not zero, returns 0. A write to such an offset changes nothing. In both cases `bus_err` is 1 in exactly the cycle after the access and 0 otherwise.
- R10: Read data appears on `bus_rdata` one cycle after the read is presented and is 0 when no read was presented. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle flag for an unmapped access |
| pin_level | input | 32 | Resolved pad levels |
| out_level | output | 32 | Output word to the pads |
| dir_mask | output | 32 | Direction word to the pads (1 = output) |

## Verification
Errors in the output or direction latch show on `out_level` or `dir_mask` in the cycle right after the write. A fault in the set or clear path therefore shows up in the same step as the write that triggers it. A wrong direction copy shows up in two places: on `dir_mask`, and in bit 0 of a configuration readback one cycle after the read. The sweep writes every pin's configuration word, then rereads that word and its neighbour, which catches an index that is shifted or shared. A decode fault on an unmapped offset shows as a stray `bus_err`, as nonzero read data, or as a change on the pad outputs one cycle after the access.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned PINS   = WORD_W;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned IDX_W  = $clog2(PINS);

    localparam logic [ADDR_W-1:0] OFS_OUT    = 12'h504;
    localparam logic [ADDR_W-1:0] OFS_OUTSET = 12'h508;
    localparam logic [ADDR_W-1:0] OFS_OUTCLR = 12'h50C;
    localparam logic [ADDR_W-1:0] OFS_IN     = 12'h510;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 12'h514;
    localparam logic [ADDR_W-1:0] OFS_DIRSET = 12'h518;
    localparam logic [ADDR_W-1:0] OFS_DIRCLR = 12'h51C;
    localparam logic [ADDR_W-1:0] CNF_BASE   = 12'h700;
    localparam logic [ADDR_W-1:0] CNF_SPAN   = ADDR_W'(PINS * 4);

    localparam logic [WORD_W-1:0] CNF_RESET  = 32'h0000_0002;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_OUT,
        SEL_OUTSET,
        SEL_OUTCLR,
        SEL_IN,
        SEL_DIR,
        SEL_DIRSET,
        SEL_DIRCLR,
        SEL_CNF
    } reg_sel_e;

    typedef enum logic [1:0] {
        WOP_NONE,
        WOP_ASSIGN,
        WOP_SET,
        WOP_CLR
    } wop_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic wop_e out_op(reg_sel_e s);
        case (s)
            SEL_OUT:    return WOP_ASSIGN;
            SEL_OUTSET: return WOP_SET;
            SEL_OUTCLR: return WOP_CLR;
            default:    return WOP_NONE;
        endcase
    endfunction

    function automatic wop_e dir_op(reg_sel_e s);
        case (s)
            SEL_DIR:    return WOP_ASSIGN;
            SEL_DIRSET: return WOP_SET;
            SEL_DIRCLR: return WOP_CLR;
            default:    return WOP_NONE;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] apply_wop(wop_e op,
                                                    logic [WORD_W-1:0] cur,
                                                    logic [WORD_W-1:0] val);
        case (op)
            WOP_ASSIGN: return val;
            WOP_SET:    return cur | val;
            WOP_CLR:    return cur & ~val;
            default:    return cur;
        endcase
    endfunction

    function automatic logic is_out_sel(reg_sel_e s);
        return (s == SEL_OUT) || (s == SEL_OUTSET) || (s == SEL_OUTCLR);
    endfunction

    function automatic logic is_dir_sel(reg_sel_e s);
        return (s == SEL_DIR) || (s == SEL_DIRSET) || (s == SEL_DIRCLR);
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_regs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    logic [ADDR_W-1:0] cnf_off;

    assign cnf_off = addr - CNF_BASE;

    always_comb begin
        dec.sel = SEL_NONE;
        dec.idx = '0;
        case (addr)
            OFS_OUT:    dec.sel = SEL_OUT;
            OFS_OUTSET: dec.sel = SEL_OUTSET;
            OFS_OUTCLR: dec.sel = SEL_OUTCLR;
            OFS_IN:     dec.sel = SEL_IN;
            OFS_DIR:    dec.sel = SEL_DIR;
            OFS_DIRSET: dec.sel = SEL_DIRSET;
            OFS_DIRCLR: dec.sel = SEL_DIRCLR;
            default: begin
                if ((cnf_off < CNF_SPAN) && (cnf_off[1:0] == 2'b00)) begin
                    dec.sel = SEL_CNF;
                    dec.idx = cnf_off[IDX_W+1:2];
                end
            end
        endcase
    end

endmodule

// File: rtl/gpio_word_latch.sv
module gpio_word_latch
    import gpio_regs_pkg::*;
#(
    parameter int unsigned W  = WORD_W,
    parameter int unsigned IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  wop_e          op,
    input  logic [W-1:0]  wdata,
    input  logic          bit_we,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (op != WOP_NONE) begin
            q <= apply_wop(op, q, wdata);
        end else if (bit_we) begin
            q[bit_idx] <= bit_val;
        end
    end

    // R1 R2
    word_assign_chk: assert property (@(posedge clk) disable iff (rst)
        (op == WOP_ASSIGN) |=> (q == $past(wdata)));

    // R1 R2
    word_set_chk: assert property (@(posedge clk) disable iff (rst)
        (op == WOP_SET) |=> (q == ($past(q) | $past(wdata))));

    // R1 R2
    word_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (op == WOP_CLR) |=> (q == ($past(q) & ~$past(wdata))));

    // R5
    single_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (op == WOP_NONE && bit_we) |=>
        ((q[$past(bit_idx)] == $past(bit_val)) &&
         (((q ^ $past(q)) & ~(W'(1) << $past(bit_idx))) == '0)));

    // R1 R2
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op == WOP_NONE && !bit_we) |=> $stable(q));

endmodule

// File: rtl/gpio_cnf_bank.sv
module gpio_cnf_bank
    import gpio_regs_pkg::*;
#(
    parameter int unsigned NP = PINS,
    parameter int unsigned UW = WORD_W - 1,
    parameter int unsigned IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [UW-1:0] wdata_hi,
    output logic [UW-1:0] rd_hi
);

    localparam logic [UW-1:0] HI_RESET = CNF_RESET[WORD_W-1:1];

    logic [UW-1:0] hi_q [NP];

    for (genvar g = 0; g < NP; g++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) begin
                hi_q[g] <= HI_RESET;
            end else if (we && (idx == IW'(g))) begin
                hi_q[g] <= wdata_hi;
            end
        end

        // R5
        cnf_other_pin_chk: assert property (@(posedge clk) disable iff (rst)
            (!(we && (idx == IW'(g)))) |=> $stable(hi_q[g]));
    end

    assign rd_hi = hi_q[idx];

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [PINS-1:0]   pin_level,
    output logic [PINS-1:0]   out_level,
    output logic [PINS-1:0]   dir_mask
);

    dec_t              dec;
    wop_e              out_wop;
    wop_e              dir_wop;
    logic              cnf_we;
    logic [PINS-1:0]   out_q;
    logic [PINS-1:0]   dir_q;
    logic [PINS-1:0]   in_q;
    logic [WORD_W-2:0] cnf_hi;
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;
    logic              err_q;

    gpio_addr_dec u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign out_wop = bus_wr ? out_op(dec.sel) : WOP_NONE;
    assign dir_wop = bus_wr ? dir_op(dec.sel) : WOP_NONE;
    assign cnf_we  = bus_wr && (dec.sel == SEL_CNF);

    gpio_word_latch #(.W(PINS), .IW(IDX_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .op      (out_wop),
        .wdata   (bus_wdata),
        .bit_we  (1'b0),
        .bit_idx ('0),
        .bit_val (1'b0),
        .q       (out_q)
    );

    // The direction word is the only storage of each pin's direction bit.
    gpio_word_latch #(.W(PINS), .IW(IDX_W)) u_dir (
        .clk     (clk),
        .rst     (rst),
        .op      (dir_wop),
        .wdata   (bus_wdata),
        .bit_we  (cnf_we),
        .bit_idx (dec.idx),
        .bit_val (bus_wdata[0]),
        .q       (dir_q)
    );

    gpio_cnf_bank #(.NP(PINS), .UW(WORD_W - 1), .IW(IDX_W)) u_cnf (
        .clk      (clk),
        .rst      (rst),
        .we       (cnf_we),
        .idx      (dec.idx),
        .wdata_hi (bus_wdata[WORD_W-1:1]),
        .rd_hi    (cnf_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q <= '0;
        end else begin
            in_q <= pin_level;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (is_out_sel(dec.sel)) begin
            rd_mux = out_q;
        end else if (is_dir_sel(dec.sel)) begin
            rd_mux = dir_q;
        end else if (dec.sel == SEL_IN) begin
            rd_mux = in_q;
        end else if (dec.sel == SEL_CNF) begin
            rd_mux = {cnf_hi, dir_q[dec.idx]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= bus_rd ? rd_mux : '0;
            err_q   <= (bus_rd || bus_wr) && (dec.sel == SEL_NONE);
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
    assign out_level = out_q;
    assign dir_mask  = dir_q;

    // R7
    reset_words_chk: assert property (@(posedge clk)
        $past(rst) |-> (out_q == '0 && dir_q == '0 && bus_err == 1'b0));

    // R9
    err_source_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> ($past(bus_rd || bus_wr) && ($past(dec.sel) == SEL_NONE)));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.sel == SEL_NONE) |=> (bus_rdata == '0));

    // R4
    cnf_dir_view_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && dec.sel == SEL_CNF) |=>
        (bus_rdata[0] == dir_q[$past(dec.idx)]));

    // R8
    in_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.sel == SEL_IN) |=> (bus_rdata == $past(in_q)));

    // R10
    idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd) |=> (bus_rdata == '0));

endmodule

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [31:0] pin_level = '0;
    logic [31:0] out_level;
    logic [31:0] dir_mask;

    int total = 0;
    int bad = 0;

    logic [31:0] out_m;
    logic [31:0] dir_m;
    logic [31:0] cnf_m [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ctrl u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .pin_level (pin_level),
        .out_level (out_level),
        .dir_mask  (dir_mask)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    function automatic logic [11:0] cnf_addr(input int n);
        return 12'(32'h700 + 4 * n);
    endfunction

    function automatic logic [31:0] cnf_exp(input int n);
        return {cnf_m[n][31:1], dir_m[n]};
    endfunction

    task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic do_rd(input logic [11:0] a, output logic [31:0] r);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        r        = bus_rdata;
        bus_rd   = 1'b0;
    endtask

    task automatic check_all_cnf(input string req);
        logic [31:0] r;
        for (int n = 0; n < 32; n++) begin
            do_rd(cnf_addr(n), r);
            check(req, r, cnf_exp(n));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog got=%08h exp=%08h", 32'h1, 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] p;
        logic [11:0] bad_addr [6];

        out_m = '0;
        dir_m = '0;
        for (int n = 0; n < 32; n++) cnf_m[n] = 32'h2;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7: reset state of the pad-facing words and of every configuration word
        check("R7 out", out_level, 32'h0);
        check("R7 dir", dir_mask, 32'h0);
        check("R7 err", {31'b0, bus_err}, 32'h0);
        check_all_cnf("R7 R6 cnf reset");

        // R1 R3: output word via all three write forms and all three read aliases
        p = 32'hA5A5_0F0F;
        for (int k = 0; k < 8; k++) begin
            p = p * 32'h9E37_79B1 + 32'(k);
            do_wr(12'h504, p);
            out_m = p;
            check("R1 assign", out_level, out_m);
            do_wr(12'h508, p ^ 32'h00FF_FF00);
            out_m = out_m | (p ^ 32'h00FF_FF00);
            check("R1 set", out_level, out_m);
            do_wr(12'h50C, {p[15:0], p[31:16]});
            out_m = out_m & ~{p[15:0], p[31:16]};
            check("R1 clear", out_level, out_m);
            do_rd(12'h504, r); check("R3 out", r, out_m);
            do_rd(12'h508, r); check("R3 outset", r, out_m);
            do_rd(12'h50C, r); check("R3 outclr", r, out_m);
            check("R2 dir untouched by out", dir_mask, dir_m);
        end

        // R2 R3 R4: direction word forms, aliases and the mirrored configuration bit
        p = 32'h1357_9BDF;
        for (int k = 0; k < 4; k++) begin
            p = p * 32'h0101_0F1D + 32'h3C3C_0001;
            do_wr(12'h514, p);
            dir_m = p;
            check("R2 assign", dir_mask, dir_m);
            check_all_cnf("R4 after dir");
            do_wr(12'h518, p >> 3);
            dir_m = dir_m | (p >> 3);
            check("R2 set", dir_mask, dir_m);
            check_all_cnf("R4 after dirset");
            do_wr(12'h51C, p << 5);
            dir_m = dir_m & ~(p << 5);
            check("R2 clear", dir_mask, dir_m);
            check_all_cnf("R4 after dirclr");
            do_rd(12'h514, r); check("R3 dir", r, dir_m);
            do_rd(12'h518, r); check("R3 dirset", r, dir_m);
            do_rd(12'h51C, r); check("R3 dirclr", r, dir_m);
            check("R1 out untouched by dir", out_level, out_m);
        end

        // R5 R6: per-pin configuration writes, direction copy, neighbour untouched
        for (int n = 0; n < 32; n++) begin
            p = (32'(n) * 32'h0404_0101) ^ 32'hC000_0300 ^ 32'((n * 7) % 2);
            do_wr(cnf_addr(n), p);
            cnf_m[n] = p;
            dir_m[n] = p[0];
            check("R5 dir copy", dir_mask, dir_m);
            do_rd(cnf_addr(n), r);
            check("R5 R6 cnf readback", r, cnf_exp(n));
            do_rd(cnf_addr((n + 1) % 32), r);
            check("R5 neighbour", r, cnf_exp((n + 1) % 32));
        end
        do_rd(12'h514, r);
        check("R5 dir word", r, dir_m);
        do_wr(12'h514, 32'hFFFF_0000);
        dir_m = 32'hFFFF_0000;
        check_all_cnf("R4 R5 upper bits kept");

        // R8: input sampling and read-only behaviour
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            pin_level = 32'h8421_1248 * 32'(k + 1) + 32'(k);
            @(negedge clk);
            do_rd(12'h510, r);
            check("R8 in", r, pin_level);
        end
        do_wr(12'h510, 32'hDEAD_BEEF);
        check("R8 in write err", {31'b0, bus_err}, 32'h0);
        check("R8 in write out", out_level, out_m);
        check("R8 in write dir", dir_mask, dir_m);
        do_rd(12'h510, r);
        check("R8 in after write", r, pin_level);

        // R9: unmapped and unaligned offsets
        bad_addr[0] = 12'h000;
        bad_addr[1] = 12'h500;
        bad_addr[2] = 12'h506;
        bad_addr[3] = 12'h520;
        bad_addr[4] = 12'h780;
        bad_addr[5] = 12'h702;
        for (int k = 0; k < 6; k++) begin
            do_wr(bad_addr[k], 32'hFFFF_FFFF);
            check("R9 wr err", {31'b0, bus_err}, 32'h1);
            check("R9 wr out", out_level, out_m);
            check("R9 wr dir", dir_mask, dir_m);
            @(negedge clk);
            check("R9 err one cycle", {31'b0, bus_err}, 32'h0);
            do_rd(bad_addr[k], r);
            check("R9 rd zero", r, 32'h0);
            check("R9 rd err", {31'b0, bus_err}, 32'h1);
        end
        check_all_cnf("R9 cnf untouched");
        do_rd(12'h504, r);
        check("R9 mapped no err", {31'b0, bus_err}, 32'h0);

        // R10: idle read data and read-before-write in one cycle
        @(negedge clk);
        check("R10 idle", bus_rdata, 32'h0);
        @(negedge clk);
        bus_addr  = 12'h504;
        bus_wdata = 32'h0F0F_F0F0;
        bus_wr    = 1'b1;
        bus_rd    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        check("R10 old value", bus_rdata, out_m);
        out_m = 32'h0F0F_F0F0;
        check("R10 new out", out_level, out_m);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule